// File: doc/BRIEF.md
# Scalar Floating-Point Sign-Inversion Unit

This unit runs one instruction: it inverts the sign of a scalar floating-point value held in a vector register file of 32 entries, each 128 bits wide. Each cycle it can take a 32-bit instruction word and a valid strobe. It checks the fixed opcode bits and reads a 2-bit precision code that selects a 16-, 32- or 64-bit element. It then decides whether the word runs, is reported as undefined, or is trapped because floating point is switched off. Three inputs set the outcome: base floating-point support, half-precision support and the floating-point enable.

An instruction that runs reads the source register and flips the top bit of element 0 at the selected width. It writes the whole 128-bit destination on the next clock edge. When merging is on, the bits above the element keep the old destination contents. When merging is off, those bits are cleared. A load port fills registers and a probe port reads them back, so the surrounding pipeline and the bench can see the architectural state.

Top module: `fneg_unit`

## Requirements
- R1: A word matches only when bits [31:24] equal 8'b00011110, bit 21 equals 1 and bits [20:10] equal 11'b00001010000. A valid word that does not match raises no flag and writes no register.
- R2: The destination index is taken from bits [4:0], the source index from bits [9:5] and the precision code from bits [23:22].
- R3: Precision code 2'b00 operates on 32 bits, 2'b01 on 64 bits and 2'b11 on 16 bits. The element width equals 8 shifted left by (code XOR 2'b10).
- R4: Precision code 2'b10 raises the undefined flag and leaves the register file unchanged.
- R5: Precision code 2'b11 raises the undefined flag when half-precision support is low. Any matching word raises the undefined flag when base floating-point support is low. Neither case writes a register.
- R6: A matching word that is not undefined but arrives while the floating-point enable is low raises the trap flag and leaves the register file unchanged.
- R7: The result's low element is the source element with only its top bit inverted. All other bits of the element pass through unchanged, including those of NaN, infinity and zero values.
- R8: With merging on, destination bits above the element keep their prior value. With merging off, they are written as zero.
- R9: Flags, register write and writeback outputs appear on the clock edge after the valid cycle. Each is a one-cycle pulse, and no flag is raised in a cycle that follows an idle cycle.
- R10: When the destination and source indices are equal, the source value read is the value before the write.
- R11: At most one of done, undefined and trap is high per instruction. Undefined outranks trap, and trap outranks execution.
- R12: While reset is high, and in the first cycle after it, done, undefined and trap are low.
- R13: The load port writes a register on the clock edge. The probe port returns a register's contents combinationally. If an executing instruction and a load target the same edge, the instruction's write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| feat_fp | input | 1 | Base floating-point support present |
| feat_half | input | 1 | Half-precision support present |
| fp_en | input | 1 | Floating-point access enabled |
| merge_en | input | 1 | Keep upper destination bits (1) or clear them (0) |
| ld_en | input | 1 | Register load strobe |
| ld_addr | input | 5 | Register index to load |
| ld_data | input | 128 | Value to load |
| probe_addr | input | 5 | Register index to read back |
| probe_data | output | 128 | Contents of the probed register |
| done | output | 1 | Instruction executed and written |
| undef | output | 1 | Instruction reported undefined |
| trap | output | 1 | Instruction trapped, floating point disabled |
| wb_addr | output | 5 | Destination index of the executed instruction |
| wb_data | output | 128 | Value written to the destination |

## Verification
On every cycle, the bound assertions check that at most one flag is high, that an idle cycle is followed by no flag, and that the reserved and half-gated codes produce the undefined flag. They also check that the trap follows a disabled enable, that the single-precision result equals the register-file read with its bit 31 inverted, and that the upper bits are zero when merging is off. Only the bench scenarios can show whole-register outcomes: that undefined and trapped words leave the file untouched, that merged upper bits match the old destination, that an instruction with equal source and destination uses the old value, and that special values keep their exponent and fraction at each width.

// File: rtl/fneg_pkg.sv
package fneg_pkg;

    // Fixed opcode fields of the accepted instruction word
    localparam logic [7:0]  OPC_TOP = 8'b0001_1110;
    localparam logic [10:0] OPC_MID = 11'b000_0101_0000;

    typedef enum logic [1:0] {
        PREC_S   = 2'b00,
        PREC_D   = 2'b01,
        PREC_RSV = 2'b10,
        PREC_H   = 2'b11
    } prec_e;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'b00,
        OUT_DONE  = 2'b01,
        OUT_UNDEF = 2'b10,
        OUT_TRAP  = 2'b11
    } outcome_e;

    typedef struct packed {
        outcome_e   outcome;
        prec_e      prec;
        logic [4:0] rd;
        logic [4:0] rn;
    } dec_s;

    // Element width in bits: 8 << (code ^ 2'b10)
    function automatic int unsigned elem_bits(prec_e p);
        logic [1:0] sh;
        sh = p ^ 2'b10;
        return 32'd8 << sh;
    endfunction

    function automatic logic opcode_hit(logic [31:0] w);
        return (w[31:24] == OPC_TOP) && w[21] && (w[20:10] == OPC_MID);
    endfunction

endpackage

// File: rtl/fneg_decode.sv
module fneg_decode
    import fneg_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] instr,
    input  logic        feat_fp,
    input  logic        feat_half,
    input  logic        fp_en,
    output dec_s        dec
);
    prec_e p;
    logic  hit;
    logic  bad_code;

    always_comb begin
        p        = prec_e'(instr[23:22]);
        hit      = valid && opcode_hit(instr);
        bad_code = (p == PREC_RSV) || ((p == PREC_H) && !feat_half);

        dec.prec = p;
        dec.rd   = instr[4:0];
        dec.rn   = instr[9:5];

        // Priority: undefined, then trap, then execute
        if (!hit)
            dec.outcome = OUT_NONE;
        else if (!feat_fp || bad_code)
            dec.outcome = OUT_UNDEF;
        else if (!fp_en)
            dec.outcome = OUT_TRAP;
        else
            dec.outcome = OUT_DONE;
    end
endmodule

// File: rtl/fneg_regfile.sv
module fneg_regfile #(
    parameter int NREGS = 32,
    parameter int VW    = 128,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic [AW-1:0] rn_addr,
    output logic [VW-1:0] rn_data,
    input  logic [AW-1:0] rd_addr,
    output logic [VW-1:0] rd_data,
    input  logic [AW-1:0] pr_addr,
    output logic [VW-1:0] pr_data,
    input  logic          ex_we,
    input  logic [AW-1:0] ex_addr,
    input  logic [VW-1:0] ex_data,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [VW-1:0] ld_data
);
    logic [VW-1:0] mem [NREGS];

    always_ff @(posedge clk) begin
        if (ex_we)
            mem[ex_addr] <= ex_data;
        else if (ld_we)
            mem[ld_addr] <= ld_data;
    end

    assign rn_data = mem[rn_addr];
    assign rd_data = mem[rd_addr];
    assign pr_data = mem[pr_addr];
endmodule

// File: rtl/fneg_datapath.sv
module fneg_datapath
    import fneg_pkg::*;
#(
    parameter int VW = 128
) (
    input  prec_e         prec,
    input  logic          merge,
    input  logic [VW-1:0] src,
    input  logic [VW-1:0] dst_old,
    output logic [VW-1:0] result
);
    localparam int NW = 3;

    // One mask and sign-bit pair for each legal width
    logic [VW-1:0] lane_mask [NW];
    logic [VW-1:0] lane_sign [NW];

    for (genvar g = 0; g < NW; g++) begin : g_lane
        localparam int W = 16 << g;
        assign lane_mask[g] = {{(VW-W){1'b0}}, {W{1'b1}}};
        assign lane_sign[g] = {{(VW-W){1'b0}}, 1'b1, {(W-1){1'b0}}};
    end

    logic [VW-1:0] mask;
    logic [VW-1:0] sign;
    logic [VW-1:0] upper;

    always_comb begin
        mask = '0;
        sign = '0;
        for (int i = 0; i < NW; i++) begin
            if (elem_bits(prec) == (32'd16 << i)) begin
                mask = lane_mask[i];
                sign = lane_sign[i];
            end
        end
        upper  = merge ? (dst_old & ~mask) : '0;
        result = upper | ((src ^ sign) & mask);
    end
endmodule

// File: rtl/fneg_unit.sv
module fneg_unit
    import fneg_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int VW    = 128,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid,
    input  logic [31:0]   instr,
    input  logic          feat_fp,
    input  logic          feat_half,
    input  logic          fp_en,
    input  logic          merge_en,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [VW-1:0] ld_data,
    input  logic [AW-1:0] probe_addr,
    output logic [VW-1:0] probe_data,
    output logic          done,
    output logic          undef,
    output logic          trap,
    output logic [AW-1:0] wb_addr,
    output logic [VW-1:0] wb_data
);
    dec_s          dec;
    logic [VW-1:0] src_data;
    logic [VW-1:0] dst_data;
    logic [VW-1:0] res;
    logic          exec_we;

    fneg_decode u_dec (
        .valid     (instr_valid),
        .instr     (instr),
        .feat_fp   (feat_fp),
        .feat_half (feat_half),
        .fp_en     (fp_en),
        .dec       (dec)
    );

    assign exec_we = (dec.outcome == OUT_DONE);

    fneg_regfile #(.NREGS(NREGS), .VW(VW)) u_rf (
        .clk     (clk),
        .rn_addr (dec.rn[AW-1:0]),
        .rn_data (src_data),
        .rd_addr (dec.rd[AW-1:0]),
        .rd_data (dst_data),
        .pr_addr (probe_addr),
        .pr_data (probe_data),
        .ex_we   (exec_we),
        .ex_addr (dec.rd[AW-1:0]),
        .ex_data (res),
        .ld_we   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data)
    );

    fneg_datapath #(.VW(VW)) u_dp (
        .prec    (dec.prec),
        .merge   (merge_en),
        .src     (src_data),
        .dst_old (dst_data),
        .result  (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            undef   <= 1'b0;
            trap    <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
        end else begin
            done  <= (dec.outcome == OUT_DONE);
            undef <= (dec.outcome == OUT_UNDEF);
            trap  <= (dec.outcome == OUT_TRAP);
            if (exec_we) begin
                wb_addr <= dec.rd[AW-1:0];
                wb_data <= res;
            end
        end
    end
endmodule

// File: rtl/fneg_unit_chk.sv
module fneg_unit_chk #(
    parameter int VW = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          instr_valid,
    input logic [31:0]   instr,
    input logic          feat_fp,
    input logic          feat_half,
    input logic          fp_en,
    input logic          merge_en,
    input logic [VW-1:0] src_data,
    input logic          done,
    input logic          undef,
    input logic          trap,
    input logic [VW-1:0] wb_data
);
    logic hit;
    logic legal;
    assign hit   = instr_valid && instr[31:24] == 8'h1E && instr[21] && instr[20:10] == 11'h050;
    assign legal = feat_fp && instr[23:22] != 2'b10 && (instr[23:22] != 2'b11 || feat_half);

    p_one_flag_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, undef, trap}));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !(done || undef || trap));

    p_reserved_undef_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && instr[23:22] == 2'b10) |=> (undef && !done));

    p_half_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && instr[23:22] == 2'b11 && !feat_half) |=> undef);

    p_trap_off_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && legal && !fp_en) |=> (trap && !done));

    p_sign_flip_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && legal && fp_en && instr[23:22] == 2'b00)
        |=> (done && wb_data[31:0] == ($past(src_data[31:0]) ^ 32'h8000_0000)));

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && legal && fp_en && !merge_en && instr[23:22] == 2'b01)
        |=> (wb_data[VW-1:64] == '0));
endmodule

bind fneg_unit fneg_unit_chk #(.VW(VW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .feat_fp     (feat_fp),
    .feat_half   (feat_half),
    .fp_en       (fp_en),
    .merge_en    (merge_en),
    .src_data    (src_data),
    .done        (done),
    .undef       (undef),
    .trap        (trap),
    .wb_data     (wb_data)
);

// File: tb/fneg_unit_tb_top.sv
`timescale 1ns/1ps
module fneg_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         instr_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic         feat_fp = 1'b1, feat_half = 1'b1, fp_en = 1'b1, merge_en = 1'b1;
    logic         ld_en = 1'b0;
    logic [4:0]   ld_addr = '0, probe_addr = '0;
    logic [127:0] ld_data = '0;
    logic [127:0] probe_data, wb_data;
    logic         done, undef, trap;
    logic [4:0]   wb_addr;

    always #2.5 clk = ~clk;

    fneg_unit dut_i (.*);

    typedef struct {
        int           kind;   // 0 none, 1 done, 2 undef, 3 trap
        logic [4:0]   addr;
        logic [127:0] data;
        string        req;
    } exp_t;

    exp_t         sbq[$];
    logic [127:0] mdl [32];
    int           n_chk = 0, n_bad = 0;
    logic         vld_d = 1'b0;
    bit           finished = 0;

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [1:0] p, logic [4:0] rn, logic [4:0] rd);
        return {8'b0001_1110, p, 1'b1, 11'b000_0101_0000, rn, rd};
    endfunction

    task automatic load(logic [4:0] a, logic [127:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        mdl[a] = d;
    endtask

    // Driver: predicts the outcome from the requirements and queues it
    task automatic issue(logic [31:0] w, string req);
        exp_t         e;
        int           esz;
        logic [127:0] m, s;
        bit           hit;
        e.req  = req;
        e.addr = w[4:0];
        e.data = '0;
        hit = (w[31:24] == 8'h1E) && w[21] && (w[20:10] == 11'h050);
        if (!hit)                                         e.kind = 0;
        else if (!feat_fp || w[23:22] == 2'b10 ||
                 (w[23:22] == 2'b11 && !feat_half))       e.kind = 2;
        else if (!fp_en)                                  e.kind = 3;
        else                                              e.kind = 1;
        if (e.kind == 1) begin
            esz    = (w[23:22] == 2'b00) ? 32 : (w[23:22] == 2'b01) ? 64 : 16;
            m      = (128'd1 << esz) - 128'd1;
            s      = 128'd1 << (esz - 1);
            e.data = (merge_en ? (mdl[w[4:0]] & ~m) : '0) | ((mdl[w[9:5]] ^ s) & m);
        end
        sbq.push_back(e);
        if (e.kind == 1) mdl[w[4:0]] = e.data;
        instr = w; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        probe_addr = w[4:0];
        #0.5;
        check(probe_data === mdl[w[4:0]], {req, " reg contents"}, probe_data, mdl[w[4:0]]);
    endtask

    always @(posedge clk) vld_d <= instr_valid;

    // Monitor: pops one expectation per accepted cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (vld_d && sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check({done, undef, trap} == {e.kind == 1, e.kind == 2, e.kind == 3},
                      {e.req, " flags"}, {125'd0, done, undef, trap},
                      {125'd0, e.kind == 1, e.kind == 2, e.kind == 3});
                if (e.kind == 1) begin
                    check(wb_data === e.data, {e.req, " wb_data"}, wb_data, e.data);
                    check(wb_addr === e.addr, {e.req, " wb_addr"}, {123'd0, wb_addr}, {123'd0, e.addr});
                end
            end else if (done || undef || trap) begin
                check(1'b0, "R9 flag without instruction", {125'd0, done, undef, trap}, '0);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=complete");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        check({done, undef, trap} == 3'b000, "R12 flags in reset", {125'd0, done, undef, trap}, '0);
        rst = 1'b0;
        @(negedge clk);
        check({done, undef, trap} == 3'b000, "R12 flags after reset", {125'd0, done, undef, trap}, '0);

        // R13 load and probe
        for (int i = 0; i < 32; i++)
            load(5'(i), {32'hA5A5_0000 + i, 32'h1234_5678, 32'h3F80_0000 + i, 32'h4000_0000 + i});
        probe_addr = 5'd7; #0.5;
        check(probe_data === mdl[7], "R13 probe after load", probe_data, mdl[7]);

        // R3 R7 R8 single, merge on and off
        merge_en = 1'b1; issue(mk(2'b00, 5'd1, 5'd2), "R7 R8 single merge");
        merge_en = 1'b0; issue(mk(2'b00, 5'd3, 5'd4), "R8 single zero upper");
        // R3 double and half
        merge_en = 1'b1; issue(mk(2'b01, 5'd5, 5'd6), "R3 double merge");
        merge_en = 1'b0; issue(mk(2'b11, 5'd7, 5'd8), "R3 half zero upper");
        merge_en = 1'b1; issue(mk(2'b11, 5'd9, 5'd10), "R3 half merge");

        // R7 special values: NaN, infinity, zero at each width
        load(5'd20, {64'hFFFF_FFFF_FFFF_FFFF, 64'h7FF8_0000_0000_0001});
        load(5'd21, {96'h1, 32'hFF80_0000});
        load(5'd22, {112'h2, 16'h0000});
        issue(mk(2'b01, 5'd20, 5'd23), "R7 double NaN");
        issue(mk(2'b00, 5'd21, 5'd24), "R7 single neg infinity");
        issue(mk(2'b11, 5'd22, 5'd25), "R7 half zero");

        // R10 source equals destination, then back to back (R9)
        issue(mk(2'b00, 5'd11, 5'd11), "R10 same register");
        issue(mk(2'b01, 5'd11, 5'd11), "R9 back to back same register");

        // R4 reserved code
        issue(mk(2'b10, 5'd12, 5'd13), "R4 reserved code");
        // R5 half gated, base feature off
        feat_half = 1'b0; issue(mk(2'b11, 5'd12, 5'd14), "R5 half disabled");
        issue(mk(2'b00, 5'd12, 5'd14), "R5 single with half disabled");
        feat_half = 1'b1; feat_fp = 1'b0;
        fp_en = 1'b0;     issue(mk(2'b00, 5'd12, 5'd15), "R11 undef over trap");
        feat_fp = 1'b1;
        // R6 trap
        issue(mk(2'b01, 5'd12, 5'd16), "R6 trap when disabled");
        issue(mk(2'b11, 5'd12, 5'd16), "R6 trap half");
        fp_en = 1'b1;

        // R1 and R2 non-matching words: each single-bit corruption of a fixed field
        issue(mk(2'b00, 5'd12, 5'd17) ^ 32'h0020_0000, "R1 bit21 clear");
        issue(mk(2'b00, 5'd12, 5'd17) ^ 32'h8000_0000, "R1 top bits differ");
        issue(mk(2'b00, 5'd12, 5'd17) ^ 32'h0000_0400, "R1 middle bits differ");
        issue(mk(2'b00, 5'd30, 5'd31), "R2 field positions");

        // R13 execute write wins over a same-edge load
        ld_en = 1'b1; ld_addr = 5'd18; ld_data = '1;
        issue(mk(2'b00, 5'd19, 5'd18), "R13 execute beats load");
        ld_en = 1'b0;

        repeat (3) @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            probe_addr = 5'(i); #0.5;
            check(probe_data === mdl[i], "R4 R6 final register sweep", probe_data, mdl[i]);
        end
        check(sbq.size() == 0, "R9 all results observed", 128'(sbq.size()), '0);
        finish_run();
    end
endmodule